// File: doc/BRIEF.md
# Sleep-State and Wake Controller

This block decides when a small 8-bit controller core may run, doze or stop its oscillator. Software sets one of two sleep request bits (a light doze or a deep stop). The block acts on a request only on the strobe that the core raises as each instruction completes. In the light doze only the CPU clock is gated: peripherals, timers, the serial port and the interrupt logic keep their clock, and any interrupt that is both pending and enabled resumes execution. In the deep stop the oscillator enable is dropped, so every clock stops, and interrupts are ignored.

A reset pin is first passed through a configurable synchronizer. It is then qualified: it must stay high for two whole machine cycles, with the oscillator enabled and stable, before the synchronous core reset is raised. When the deep stop sees the pin go high, the oscillator enable comes back at once, and the core reset is held until the oscillator-stable input has been high for a programmable run of consecutive cycles. When a reset ends the light doze, the CPU clock returns before the reset has been qualified, so the block raises a RAM write inhibit until the core reset takes over. Port writes are left alone. Both request bits clear themselves whenever a sleep state is left and whenever a reset is qualified.

Top module: `sleep_ctrl`

## Requirements
- R1: After the power-on reset the block is running: `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `core_rst` and `ram_wr_block` are 0.
- R2: A sleep request bit set with `set_idle` or `set_pdown` takes effect only in the cycle after a clock edge at which `insn_done` is high. Without that strobe the CPU clock stays enabled.
- R3: In the light doze `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` stay 1.
- R4: The light doze ends, and `cpu_clk_en` returns one cycle later, only when some bit i has both `irq_pend[i]` and `irq_en[i]` high. A pending interrupt whose enable is low has no effect.
- R5: When both request bits are set, `insn_done` selects the deep stop: `osc_en`, `per_clk_en` and `cpu_clk_en` all go to 0.
- R6: In the deep stop, pending and enabled interrupts leave all three enables at 0.
- R7: `core_rst` rises exactly SYNC_STAGES + 2*MC_CLKS clock edges after `rst_pin` goes high, provided the pin stays high and `osc_en` and `osc_stable` are 1 throughout. A pulse of 2*MC_CLKS-1 clocks never raises it.
- R8: When the synchronized reset pin rises during the light doze, `cpu_clk_en` and `ram_wr_block` become 1 on the next edge. `ram_wr_block` stays 1 until the edge after `core_rst` rises, and then falls while `core_rst` stays 1.
- R9: In the deep stop, a high synchronized reset pin sets `osc_en` to 1 on the next edge with `core_rst` at 1. `core_rst` stays high until `osc_stable` has been high for STABLE_CYC consecutive edges, and falls on the edge after that.
- R10: After the block leaves the light doze or the deep stop, an `insn_done` strobe with no new request keeps the CPU running.
- R11: A qualified reset clears a pending sleep request, so a later `insn_done` does not enter a sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | External reset pin, active high, asynchronous |
| osc_stable | input | 1 | Oscillator has settled |
| insn_done | input | 1 | Strobe from the core: current instruction completed |
| set_idle | input | 1 | Software write that sets the light-doze request bit |
| set_pdown | input | 1 | Software write that sets the deep-stop request bit |
| irq_pend | input | N_IRQ | Interrupt sources pending |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral and interrupt-logic clock enable |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Synchronous reset to the core and its special registers |
| ram_wr_block | output | 1 | Inhibit on internal RAM write enables |

## Verification
The interrupt wake is tried in two ways. A pending source whose enable is low shows that the enable mask is honoured. A matching pend-and-enable pair shows that the wake takes exactly one cycle. The reset pin is driven once for one clock less than the qualifying window and once for longer, which separates a correct counter limit from an off-by-one. The deep-stop exit is tried with the pin high while the oscillator is still unstable, which shows that the oscillator restarts before its stable count begins. Setting both request bits at once shows which mode wins, and a bare `insn_done` after each exit shows whether the request bits cleared themselves.

// File: rtl/slp_pkg.sv
package slp_pkg;
   typedef enum logic [2:0] {
      S_RUN      = 3'd0,
      S_IDLE     = 3'd1,
      S_IDLE_RST = 3'd2,
      S_PDOWN    = 3'd3,
      S_WAKE     = 3'd4
   } slp_state_e;
endpackage

// File: rtl/slp_pin_sync.sv
module slp_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_ni,
   input  logic d,
   output logic q
);
   if (STAGES < 0) begin : g_bad
      $error("slp_pin_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_ni) begin
         if (!rst_ni) sh <= '0;
         else         sh <= {sh[STAGES-2+1-1:0], d} >> 0;
      end
      assign q = sh[STAGES-1];
   end
endmodule

// File: rtl/slp_rst_qual.sv
module slp_rst_qual #(
   parameter int HOLD_CYC = 24
) (
   input  logic clk,
   input  logic rst_ni,
   input  logic pin,
   input  logic osc_run,
   output logic qual
);
   localparam int CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] LIM = CW'(HOLD_CYC);

   if (HOLD_CYC < 1) begin : g_bad
      $error("slp_rst_qual: HOLD_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)                cnt <= '0;
      else if (!pin || !osc_run)  cnt <= '0;
      else if (cnt != LIM)        cnt <= cnt + 1'b1;
   end

   assign qual = (cnt == LIM);

   AST_QUAL_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_ni)
      qual |-> $past(pin && osc_run)); // R7
endmodule

// File: rtl/slp_stable_timer.sv
module slp_stable_timer #(
   parameter int STABLE_CYC = 16
) (
   input  logic clk,
   input  logic rst_ni,
   input  logic run,
   input  logic stable,
   output logic done
);
   localparam int CW = $clog2(STABLE_CYC + 1);
   localparam logic [CW-1:0] LIM = CW'(STABLE_CYC);

   if (STABLE_CYC < 1) begin : g_bad
      $error("slp_stable_timer: STABLE_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)              cnt <= '0;
      else if (!run || !stable) cnt <= '0;
      else if (cnt != LIM)      cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LIM);

   AST_DONE_NEEDS_STABLE: assert property (@(posedge clk) disable iff (!rst_ni)
      done |-> $past(stable && run)); // R9
endmodule

// File: rtl/sleep_ctrl.sv
module sleep_ctrl
   import slp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MC_CLKS     = 12,
   parameter int RST_MC      = 2,
   parameter int STABLE_CYC  = 16,
   parameter int N_IRQ       = 5
) (
   input  logic             clk,
   input  logic             rst_ni,
   input  logic             rst_pin,
   input  logic             osc_stable,
   input  logic             insn_done,
   input  logic             set_idle,
   input  logic             set_pdown,
   input  logic [N_IRQ-1:0] irq_pend,
   input  logic [N_IRQ-1:0] irq_en,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic             osc_en,
   output logic             core_rst,
   output logic             ram_wr_block
);
   localparam int RST_CYC = MC_CLKS * RST_MC;

   if (MC_CLKS < 1 || RST_MC < 1 || N_IRQ < 1) begin : g_bad
      $error("sleep_ctrl: MC_CLKS, RST_MC and N_IRQ must be at least 1");
   end

   slp_state_e st, nxt;
   logic       pin_s, rst_q, stb_done, osc_run, wake_irq;
   logic       req_idle, req_pd, req_clr;

   slp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_ni(rst_ni), .d(rst_pin), .q(pin_s));

   assign osc_run = osc_en && osc_stable;

   slp_rst_qual #(.HOLD_CYC(RST_CYC)) u_qual (
      .clk(clk), .rst_ni(rst_ni), .pin(pin_s), .osc_run(osc_run), .qual(rst_q));

   slp_stable_timer #(.STABLE_CYC(STABLE_CYC)) u_stb (
      .clk(clk), .rst_ni(rst_ni), .run(st == S_WAKE), .stable(osc_stable),
      .done(stb_done));

   assign wake_irq = |(irq_pend & irq_en);

   always_comb begin
      nxt = st;
      unique case (st)
         S_RUN: begin
            if (!rst_q && insn_done) begin
               if (req_pd)        nxt = S_PDOWN;
               else if (req_idle) nxt = S_IDLE;
            end
         end
         S_IDLE: begin
            if (pin_s)         nxt = S_IDLE_RST;
            else if (wake_irq) nxt = S_RUN;
         end
         S_IDLE_RST: begin
            if (rst_q)       nxt = S_RUN;
            else if (!pin_s) nxt = S_IDLE;
         end
         S_PDOWN: if (pin_s)    nxt = S_WAKE;
         S_WAKE:  if (stb_done) nxt = S_RUN;
         default: nxt = S_RUN;
      endcase
   end

   assign req_clr = rst_q
                 || (st == S_IDLE  && nxt == S_RUN)
                 || (st == S_PDOWN && nxt == S_WAKE);

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
         st       <= S_RUN;
         req_idle <= 1'b0;
         req_pd   <= 1'b0;
      end else begin
         st <= nxt;
         if (req_clr) begin
            req_idle <= 1'b0;
            req_pd   <= 1'b0;
         end else begin
            if (set_idle)  req_idle <= 1'b1;
            if (set_pdown) req_pd   <= 1'b1;
         end
      end
   end

   assign cpu_clk_en   = (st == S_RUN) || (st == S_IDLE_RST);
   assign per_clk_en   = cpu_clk_en || (st == S_IDLE);
   assign osc_en       = (st != S_PDOWN);
   assign core_rst     = rst_q || (st == S_WAKE);
   assign ram_wr_block = (st == S_IDLE_RST);

   AST_CPU_NEEDS_PER: assert property (@(posedge clk) disable iff (!rst_ni)
      cpu_clk_en |-> per_clk_en); // R3
   AST_NO_OSC_NO_CLK: assert property (@(posedge clk) disable iff (!rst_ni)
      !osc_en |-> (!per_clk_en && !cpu_clk_en)); // R5
   AST_RUN_WITHOUT_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
      (st == S_RUN && !insn_done) |=> cpu_clk_en); // R2
   AST_IDLE_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_ni)
      (st == S_IDLE && !pin_s && wake_irq) |=> cpu_clk_en); // R4
   AST_PD_IGNORES_IRQ: assert property (@(posedge clk) disable iff (!rst_ni)
      (st == S_PDOWN && !pin_s) |=> !osc_en); // R6
   AST_OSC_RESTART_RST: assert property (@(posedge clk) disable iff (!rst_ni)
      $rose(osc_en) |-> core_rst); // R9
   AST_INHIBIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_ni)
      $fell(ram_wr_block) |-> (core_rst || !cpu_clk_en)); // R8
endmodule

// File: tb/sleep_ctrl_bench.sv
module sleep_ctrl_bench;
   localparam int SYNC   = 2;
   localparam int MC     = 12;
   localparam int RMC    = 2;
   localparam int RCYC   = MC * RMC;
   localparam int STB    = 16;
   localparam int NIRQ   = 5;

   logic clk = 1'b0;
   logic rst_ni, rst_pin, osc_stable, insn_done, set_idle, set_pdown;
   logic [NIRQ-1:0] irq_pend, irq_en;
   logic cpu_clk_en, per_clk_en, osc_en, core_rst, ram_wr_block;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sleep_ctrl #(.SYNC_STAGES(SYNC), .MC_CLKS(MC), .RST_MC(RMC),
                .STABLE_CYC(STB), .N_IRQ(NIRQ)) u_sleep_ctrl (
      .clk(clk), .rst_ni(rst_ni), .rst_pin(rst_pin), .osc_stable(osc_stable),
      .insn_done(insn_done), .set_idle(set_idle), .set_pdown(set_pdown),
      .irq_pend(irq_pend), .irq_en(irq_en), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .osc_en(osc_en), .core_rst(core_rst),
      .ram_wr_block(ram_wr_block));

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_done();
      insn_done = 1'b1; step(1); insn_done = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "cpu_clk_en", cpu_clk_en, 1);
      chk("R1", "per_clk_en", per_clk_en, 1);
      chk("R1", "osc_en", osc_en, 1);
      chk("R1", "core_rst", core_rst, 0);
      chk("R1", "ram_wr_block", ram_wr_block, 0);
   endtask

   task automatic t_idle_entry();
      set_idle = 1'b1; step(1); set_idle = 1'b0;
      step(4);
      chk("R2", "no strobe keeps cpu", cpu_clk_en, 1);
      pulse_done();
      chk("R2", "cpu gated after strobe", cpu_clk_en, 0);
      chk("R3", "per clock kept", per_clk_en, 1);
      chk("R3", "osc kept", osc_en, 1);
   endtask

   task automatic t_idle_irq();
      irq_pend = 5'b00100; irq_en = 5'b00010;
      step(3);
      chk("R4", "masked irq ignored", cpu_clk_en, 0);
      irq_en = 5'b00100;
      step(1);
      chk("R4", "enabled irq wakes", cpu_clk_en, 1);
      irq_pend = '0; irq_en = '0;
      pulse_done();
      step(1);
      chk("R10", "idle bit cleared on exit", cpu_clk_en, 1);
   endtask

   task automatic t_pd_priority();
      set_idle = 1'b1; set_pdown = 1'b1; step(1);
      set_idle = 1'b0; set_pdown = 1'b0;
      pulse_done();
      chk("R5", "osc stopped", osc_en, 0);
      chk("R5", "per stopped", per_clk_en, 0);
      chk("R5", "cpu stopped", cpu_clk_en, 0);
      osc_stable = 1'b0;
      irq_pend = 5'b11111; irq_en = 5'b11111;
      step(4);
      chk("R6", "irq ignored in deep stop", osc_en, 0);
      chk("R6", "cpu stays off", cpu_clk_en, 0);
      irq_pend = '0; irq_en = '0;
   endtask

   task automatic t_pd_exit();
      rst_pin = 1'b1;
      step(SYNC);
      chk("R9", "osc still off before sync", osc_en, 0);
      step(1);
      chk("R9", "osc restarted", osc_en, 1);
      chk("R9", "core held in reset", core_rst, 1);
      rst_pin = 1'b0;
      step(3);
      osc_stable = 1'b1;
      step(STB);
      chk("R9", "reset held through stable count", core_rst, 1);
      step(1);
      chk("R9", "reset released", core_rst, 0);
      chk("R9", "cpu running", cpu_clk_en, 1);
      pulse_done();
      step(1);
      chk("R10", "pd bit cleared on exit", osc_en, 1);
      chk("R10", "cpu still running", cpu_clk_en, 1);
   endtask

   task automatic t_rst_qual();
      int seen;
      seen = 0;
      rst_pin = 1'b1; step(RCYC - 1); rst_pin = 1'b0;
      for (int i = 0; i < SYNC + 6; i++) begin
         if (core_rst) seen = 1;
         step(1);
      end
      chk("R7", "short pulse rejected", seen, 0);
      set_idle = 1'b1; step(1); set_idle = 1'b0;
      rst_pin = 1'b1;
      step(SYNC + RCYC - 1);
      chk("R7", "not yet qualified", core_rst, 0);
      step(1);
      chk("R7", "qualified reset", core_rst, 1);
      rst_pin = 1'b0;
      step(SYNC + 2);
      chk("R7", "reset released", core_rst, 0);
      pulse_done();
      step(1);
      chk("R11", "request cleared by reset", cpu_clk_en, 1);
   endtask

   task automatic t_idle_reset();
      set_idle = 1'b1; step(1); set_idle = 1'b0;
      pulse_done();
      chk("R8", "in idle", cpu_clk_en, 0);
      rst_pin = 1'b1;
      step(SYNC);
      chk("R8", "inhibit not yet", ram_wr_block, 0);
      step(1);
      chk("R8", "inhibit on", ram_wr_block, 1);
      chk("R8", "cpu clock back", cpu_clk_en, 1);
      step(RCYC - 1);
      chk("R8", "core_rst rises", core_rst, 1);
      chk("R8", "inhibit overlaps reset", ram_wr_block, 1);
      step(1);
      chk("R8", "inhibit released", ram_wr_block, 0);
      chk("R8", "reset still held", core_rst, 1);
      rst_pin = 1'b0;
      step(SYNC + 2);
   endtask

   initial begin
      rst_ni = 1'b0; rst_pin = 1'b0; osc_stable = 1'b1; insn_done = 1'b0;
      set_idle = 1'b0; set_pdown = 1'b0; irq_pend = '0; irq_en = '0;
      step(3);
      rst_ni = 1'b1;
      step(1);
      t_reset();
      t_idle_entry();
      t_idle_irq();
      t_pd_priority();
      t_pd_exit();
      t_rst_qual();
      t_idle_reset();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule